// File: doc/BRIEF.md
# Timestamp LRU Set Controller

This block keeps the replacement state of one set of a set-associative cache. Each of `WAYS` ways holds a valid flag, a tag and a 64-bit timestamp. A single global timestamp counter orders all uses. A command presented on the command port is decoded combinationally against the current state:
- `hit`, `hit_way` and `hit_stamp` report whether the tag is present.
- `victim_way` and `victim_stamp` report the way that a fill would replace.

The state update for a command takes effect at the next rising clock edge when `cmd_valid` is high.

Four commands exist:
- A lookup touches a hit way.
- A demand install places a missing block at the most-recent position.
- A prefetch install places a missing block at the most-recent position or just below the oldest position, selected by `pf_lip`. It does nothing if the block is already present.
- A probe only reads the state.

The global counter advances by one on every touch and every fill, and at no other time. A cycle-accurate reference model can therefore follow the update order step by step.

Top module: `lru_set_ctrl`

## Requirements
- R1: Reset (`rst_n` low, synchronous) clears every valid flag and loads `stamp_now` with 2^(CACHE_LOG2-BLOCK_LOG2+1), which is 32 at the default parameters.
- R2: `hit` is high when a valid way holds `cmd_tag`. `hit_way` and `hit_stamp` then give the lowest such way and its timestamp. On a miss, both read 0.
- R3: `victim_way` is the lowest-index invalid way if one exists, and `victim_stamp` is then 0. Otherwise `victim_way` is the valid way with the smallest timestamp, and `victim_stamp` is that timestamp.
- R4: Opcode 0 (lookup) on a hit writes `stamp_now` into the hit way's timestamp, then increments `stamp_now`. On a miss it changes nothing.
- R5: Opcode 1 (demand install) on a miss writes the tag into the victim way, marks it valid, gives it timestamp `stamp_now`, and increments `stamp_now`. On a hit it acts as a lookup touch.
- R6: Opcode 2 (prefetch install) that hits changes no timestamp and does not increment `stamp_now`.
- R7: Opcode 2 on a miss with `pf_lip`=0 fills the victim way with timestamp `stamp_now`, then increments `stamp_now`.
- R8: Opcode 2 on a miss with `pf_lip`=1 fills the victim way with timestamp (smallest valid timestamp in the set) − 1, or with `stamp_now` if no way was valid. `stamp_now` increments in both cases.
- R9: Opcode 3 (probe) changes no state.
- R10: With `cmd_valid` low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command applies at the next edge |
| cmd_op | input | 2 | 0 lookup, 1 demand install, 2 prefetch install, 3 probe |
| cmd_tag | input | TAG_W | Tag of the command |
| pf_lip | input | 1 | Prefetch fill below the oldest way when 1 |
| hit | output | 1 | Tag present |
| hit_way | output | WAY_W | Way holding the tag |
| hit_stamp | output | TS_W | Timestamp of the hit way |
| victim_way | output | WAY_W | Way a fill would replace |
| victim_stamp | output | TS_W | Timestamp of the victim, 0 if invalid |
| stamp_now | output | TS_W | Global timestamp counter |

## Verification
A vector table fills an empty set with a mix of demand and prefetch installs under both insertion policies. It then touches, probes and evicts, checking the exposed timestamps and counter before every edge. Prefetch hits, probes and lookup misses sit between counting operations, so any stray counter increment shifts every later expected stamp. Two consecutive fills below the oldest way show that the written value tracks the current minimum rather than a fixed position. Directed steps cover the policy on an empty set after reset, a demand install that hits, and an idle cycle.

// File: rtl/lru_set_ctrl.sv
module lru_set_ctrl #(
  parameter int WAYS       = 4,
  parameter int TAG_W      = 8,
  parameter int CACHE_LOG2 = 10,
  parameter int BLOCK_LOG2 = 6,
  parameter int TS_W       = 64,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             pf_lip,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [TS_W-1:0]  hit_stamp,
  output logic [WAY_W-1:0] victim_way,
  output logic [TS_W-1:0]  victim_stamp,
  output logic [TS_W-1:0]  stamp_now
);
  localparam logic [1:0] OP_LOOKUP = 2'd0;
  localparam logic [1:0] OP_DEMAND = 2'd1;
  localparam logic [1:0] OP_PREF   = 2'd2;
  localparam logic [TS_W-1:0] TS_INIT = TS_W'(1) << (CACHE_LOG2 - BLOCK_LOG2 + 1);

  logic [WAYS-1:0]  vld;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [TS_W-1:0]  ts_q  [WAYS];

  logic             free_found, any_v;
  logic [WAY_W-1:0] free_idx, min_idx;
  logic [TS_W-1:0]  min_ts;

  always_comb begin
    hit = 1'b0; hit_way = '0;
    free_found = 1'b0; free_idx = '0;
    any_v = 1'b0; min_idx = '0; min_ts = '1;
    for (int i = 0; i < WAYS; i++) begin
      if (vld[i] && tag_q[i] == cmd_tag && !hit) begin
        hit = 1'b1; hit_way = WAY_W'(i);
      end
      if (!vld[i] && !free_found) begin
        free_found = 1'b1; free_idx = WAY_W'(i);
      end
      if (vld[i] && (!any_v || ts_q[i] < min_ts)) begin
        any_v = 1'b1; min_ts = ts_q[i]; min_idx = WAY_W'(i);
      end
    end
  end

  assign hit_stamp    = hit ? ts_q[hit_way] : '0;
  assign victim_way   = free_found ? free_idx : min_idx;
  assign victim_stamp = free_found ? '0 : min_ts;

  wire do_touch = cmd_valid && hit && (cmd_op == OP_LOOKUP || cmd_op == OP_DEMAND);
  wire do_fill  = cmd_valid && !hit && (cmd_op == OP_DEMAND || cmd_op == OP_PREF);
  wire [TS_W-1:0] low_ts  = any_v ? min_ts - 1'b1 : stamp_now;
  wire [TS_W-1:0] fill_ts = (cmd_op == OP_PREF && pf_lip) ? low_ts : stamp_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      stamp_now <= TS_INIT;
    end else if (do_touch) begin
      ts_q[hit_way] <= stamp_now;
      stamp_now     <= stamp_now + 1'b1;
    end else if (do_fill) begin
      vld[victim_way]   <= 1'b1;
      tag_q[victim_way] <= cmd_tag;
      ts_q[victim_way]  <= fill_ts;
      stamp_now         <= stamp_now + 1'b1;
    end
  end
endmodule

module lru_set_ctrl_chk #(parameter int TS_W = 64) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic            hit,
  input logic [TS_W-1:0] stamp_now
);
  p_lookup_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && !hit) |=> $stable(stamp_now));
  p_demand_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |=> stamp_now == $past(stamp_now) + 1'b1);
  p_pref_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && hit) |=> $stable(stamp_now));
  p_pref_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && !hit) |=> stamp_now == $past(stamp_now) + 1'b1);
  p_probe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> $stable(stamp_now));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(stamp_now));
endmodule

bind lru_set_ctrl lru_set_ctrl_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .hit(hit), .stamp_now(stamp_now));

// File: tb/tb_lru_set_ctrl.sv
module tb_lru_set_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, pf_lip = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_tag = '0;
  logic hit;
  logic [1:0] hit_way, victim_way;
  logic [63:0] hit_stamp, victim_stamp, stamp_now;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lru_set_ctrl dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tag(cmd_tag), .pf_lip(pf_lip), .hit(hit), .hit_way(hit_way), .hit_stamp(hit_stamp),
    .victim_way(victim_way), .victim_stamp(victim_stamp), .stamp_now(stamp_now));

  // op, lip, tag, hit, hit_way, victim_way, stamp_now, hit_stamp, victim_stamp
  localparam int N = 16;
  localparam logic [39:0] VEC [N] = '{
    {2'd0,1'b0,8'h10,1'b0,2'd0,2'd0,8'd32,8'd0, 8'd0},
    {2'd1,1'b0,8'h10,1'b0,2'd0,2'd0,8'd32,8'd0, 8'd0},
    {2'd1,1'b0,8'h20,1'b0,2'd0,2'd1,8'd33,8'd0, 8'd0},
    {2'd0,1'b0,8'h10,1'b1,2'd0,2'd2,8'd34,8'd32,8'd0},
    {2'd2,1'b0,8'h10,1'b1,2'd0,2'd2,8'd35,8'd34,8'd0},
    {2'd2,1'b1,8'h30,1'b0,2'd0,2'd2,8'd35,8'd0, 8'd0},
    {2'd1,1'b0,8'h40,1'b0,2'd0,2'd3,8'd36,8'd0, 8'd0},
    {2'd3,1'b0,8'h30,1'b1,2'd2,2'd2,8'd37,8'd32,8'd32},
    {2'd0,1'b0,8'h20,1'b1,2'd1,2'd2,8'd37,8'd33,8'd32},
    {2'd2,1'b1,8'h50,1'b0,2'd0,2'd2,8'd38,8'd0, 8'd32},
    {2'd3,1'b0,8'h50,1'b1,2'd2,2'd2,8'd39,8'd31,8'd31},
    {2'd2,1'b0,8'h60,1'b0,2'd0,2'd2,8'd39,8'd0, 8'd31},
    {2'd3,1'b0,8'h10,1'b1,2'd0,2'd0,8'd40,8'd34,8'd34},
    {2'd1,1'b0,8'h70,1'b0,2'd0,2'd0,8'd40,8'd0, 8'd34},
    {2'd0,1'b0,8'h10,1'b0,2'd0,2'd3,8'd41,8'd0, 8'd36},
    {2'd3,1'b0,8'h70,1'b1,2'd0,2'd3,8'd41,8'd40,8'd36}
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic lip, input logic [7:0] tag);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; pf_lip = lip; cmd_tag = tag;
    #5;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #5;
    check("R1", "stamp_now after reset", stamp_now, 64'd32);
    check("R3", "victim on empty set", {62'd0, victim_way}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      logic [39:0] v;
      string rq;
      v = VEC[i];
      drive(1'b1, v[39:38], v[37], v[36:29]);
      case (v[39:38])
        2'd0: rq = "R4";
        2'd1: rq = "R5";
        2'd2: rq = v[28] ? "R6" : (v[37] ? "R8" : "R7");
        default: rq = "R9";
      endcase
      check("R2", "hit", {63'd0, hit}, {63'd0, v[28]});
      check("R2", "hit_way", {62'd0, hit_way}, {62'd0, v[27:26]});
      check("R2", "hit_stamp", hit_stamp, {56'd0, v[15:8]});
      check("R3", "victim_way", {62'd0, victim_way}, {62'd0, v[25:24]});
      check("R3", "victim_stamp", victim_stamp, {56'd0, v[7:0]});
      check(rq, "stamp_now", stamp_now, {56'd0, v[23:16]});
    end
    // R1: reset in mid-run empties the set and reloads the counter
    drive(1'b0, 2'd0, 1'b0, 8'h70);
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 1'b0, 8'h70);
    rst_n = 1'b1;
    check("R1", "stamp_now reload", stamp_now, 64'd32);
    check("R1", "hit after reset", {63'd0, hit}, 64'd0);
    check("R1", "victim after reset", {62'd0, victim_way}, 64'd0);
    // R8: low-position fill into an empty set takes the counter value
    drive(1'b1, 2'd2, 1'b1, 8'h11);
    drive(1'b1, 2'd3, 1'b0, 8'h11);
    check("R8", "empty-set fill stamp", hit_stamp, 64'd32);
    check("R8", "counter after fill", stamp_now, 64'd33);
    // R5: demand install that hits acts as a touch
    drive(1'b1, 2'd1, 1'b0, 8'h11);
    drive(1'b1, 2'd3, 1'b0, 8'h11);
    check("R5", "demand hit stamp", hit_stamp, 64'd33);
    check("R5", "demand hit counter", stamp_now, 64'd34);
    check("R5", "demand hit kept way", {62'd0, victim_way}, 64'd1);
    // R10: invalid command leaves state alone
    drive(1'b0, 2'd0, 1'b0, 8'h11);
    drive(1'b0, 2'd1, 1'b0, 8'h22);
    drive(1'b1, 2'd3, 1'b0, 8'h11);
    check("R10", "idle counter", stamp_now, 64'd34);
    check("R10", "idle stamp", hit_stamp, 64'd33);
    drive(1'b1, 2'd3, 1'b0, 8'h22);
    check("R10", "idle no fill", {63'd0, hit}, 64'd0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule